// File: doc/BRIEF.md
# SPI Slave Hold-Pause Controller

This block sits at the pin edge of a serial-flash style SPI slave. It decides when the serial interface is paused by the hold pin. The inputs are chip select, hold, serial clock and serial data. Each pin is brought into the system clock domain through a two-stage synchronizer. A small state machine then tracks three conditions: normal operation, a paused interface, and a lockout that follows a deselect during the pause. Hold entry and hold exit are both qualified by the serial clock: they take effect only while the clock is low. If the clock is high at the request, the change waits until the clock next falls.

From that state the block makes the controls for the internal command engine. These are a shift enable, a one-cycle bit strobe carrying the sampled data bit, the output-enable for the data-out driver, and a one-cycle reset pulse for the interface logic. The busy flag of the program and erase machinery passes straight through the block. No hold, deselect or lockout event ever alters it. There is no streaming data path, so all ports are plain level or pulse signals.

Top module: `spi_hold_ctl`

## Requirements
- R1: While the synchronous active-high `rst` is high, and on the first cycle after it, `hold_active`, `shift_enable`, `do_oe`, `iface_reset` and `bit_strobe` are all 0.
- R2: Every pin goes through two synchronizer flops and then one output register. A pin change made just after a system clock edge reaches the outputs on the third rising edge after it.
- R3: A paused condition can only begin while the chip is selected (`cs_n` low). Driving `hold_n` low while `cs_n` is high leaves `hold_active` at 0 and does not pulse `iface_reset`.
- R4: With the chip selected, a low `hold_n` starts the pause at once when `sclk` is low. When `sclk` is high, the start waits until `sclk` goes low.
- R5: A high `hold_n` ends the pause at once when `sclk` is low. When `sclk` is high, the end waits until `sclk` goes low.
- R6: While `hold_active` is 1, `shift_enable`, `do_oe` and `bit_strobe` are 0, whatever `sclk` and `di` do.
- R7: A pause with `cs_n` kept low keeps the interface state. Bits shifted before the pause and bits shifted after it join into one sequence, and no `iface_reset` pulse occurs.
- R8: `busy_out` always equals `busy_in`, during normal operation, during a pause and during lockout.
- R9: Raising `cs_n` during a pause clears `hold_active` and produces exactly one `iface_reset` pulse, one system clock cycle long.
- R10: After such a deselect, the block stays locked. `shift_enable` stays 0 and no new pause can begin, even when `cs_n` goes low again or `hold_n` rises while `cs_n` is low. The lock ends only once `hold_n` and `cs_n` are both high. The next selection then works normally.
- R11: While the chip is selected and not paused, each rising `sclk` edge gives one `bit_strobe` pulse of one cycle. `bit_data` carries the `di` level sampled at that edge. No strobe occurs while `cs_n` is high.
- R12: `do_oe` is 1 only when `tx_req` is 1 and `shift_enable` is 1. It follows `tx_req` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| hold_n | input | 1 | Hold pin, active low, asynchronous |
| sclk | input | 1 | Serial clock pin, asynchronous |
| di | input | 1 | Serial data input pin, asynchronous |
| tx_req | input | 1 | Command engine wants to drive the data output |
| busy_in | input | 1 | Program/erase/status-write busy from the engine |
| hold_active | output | 1 | Interface is paused |
| shift_enable | output | 1 | Command engine may shift and count bits |
| do_oe | output | 1 | Output enable for the data-out driver |
| iface_reset | output | 1 | One-cycle reset of shift register, bit counter and command phase |
| bit_strobe | output | 1 | One-cycle pulse per accepted rising serial clock edge |
| bit_data | output | 1 | Data bit sampled with the latest strobe |
| busy_out | output | 1 | Busy flag, passed through unchanged |

## Verification
A wrong state shows at the ports within three system clock cycles of the pin change that should have caused it. A pause entered too early, or missed, shows as `hold_active` at the wrong level while `sclk` is high. A pause that does not freeze the interface shows as extra `bit_strobe` pulses, and so as a wrong assembled byte. A lockout that ends too soon shows as `shift_enable` rising while `cs_n` is reselected with `hold_n` still low. A missing or doubled deselect reset shows in the count of `iface_reset` pulses.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_LOCK = 2'd2
  } hold_state_e;

  localparam int NUM_PINS = 4;

  typedef struct packed {
    logic di;
    logic sclk;
    logic hold_n;
    logic cs_n;
  } pin_vec_t;

  localparam pin_vec_t PIN_IDLE = '{di: 1'b0, sclk: 1'b0, hold_n: 1'b1, cs_n: 1'b1};

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n_s,
  input  logic        hold_n_s,
  input  logic        sclk_s,
  output hold_state_e state_q,
  output hold_state_e state_d,
  output logic        deselect_in_pause
);
  // Pause changes are only taken while the serial clock is low; a
  // request made while it is high simply waits for the low level.
  logic clk_low;
  assign clk_low = ~sclk_s;
  assign deselect_in_pause = (state_q == ST_PAUSE) && cs_n_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (!cs_n_s && !hold_n_s && clk_low) state_d = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (cs_n_s)                      state_d = ST_LOCK;
        else if (hold_n_s && clk_low)    state_d = ST_RUN;
      end
      ST_LOCK: begin
        if (cs_n_s && hold_n_s)          state_d = ST_RUN;
      end
      default:                           state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/spi_hold_outputs.sv
module spi_hold_outputs
  import spi_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  hold_state_e state_q,
  input  hold_state_e state_d,
  input  logic        deselect_in_pause,
  input  logic        cs_n_s,
  input  logic        sclk_s,
  input  logic        di_s,
  input  logic        tx_req,
  output logic        hold_active,
  output logic        shift_enable,
  output logic        do_oe,
  output logic        iface_reset,
  output logic        bit_strobe,
  output logic        bit_data
);
  logic sclk_prev;
  logic run_next;
  logic take_bit;

  assign run_next = (state_d == ST_RUN) && !cs_n_s;
  assign take_bit = sclk_s && !sclk_prev && (state_q == ST_RUN) && !cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev    <= 1'b0;
      hold_active  <= 1'b0;
      shift_enable <= 1'b0;
      do_oe        <= 1'b0;
      iface_reset  <= 1'b0;
      bit_strobe   <= 1'b0;
      bit_data     <= 1'b0;
    end else begin
      sclk_prev    <= sclk_s;
      hold_active  <= (state_d == ST_PAUSE);
      shift_enable <= run_next;
      do_oe        <= run_next && tx_req;
      iface_reset  <= deselect_in_pause;
      bit_strobe   <= take_bit;
      if (take_bit) bit_data <= di_s;
    end
  end
endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic hold_n,
  input  logic sclk,
  input  logic di,
  input  logic tx_req,
  input  logic busy_in,
  output logic hold_active,
  output logic shift_enable,
  output logic do_oe,
  output logic iface_reset,
  output logic bit_strobe,
  output logic bit_data,
  output logic busy_out
);
  pin_vec_t    pins_raw;
  pin_vec_t    pins_s;
  hold_state_e state_q;
  hold_state_e state_d;
  logic        deselect_in_pause;

  assign pins_raw = '{di: di, sclk: sclk, hold_n: hold_n, cs_n: cs_n};

  spi_hold_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) i_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in (pins_raw),
    .q_out(pins_s)
  );

  spi_hold_fsm i_fsm (
    .clk              (clk),
    .rst              (rst),
    .cs_n_s           (pins_s.cs_n),
    .hold_n_s         (pins_s.hold_n),
    .sclk_s           (pins_s.sclk),
    .state_q          (state_q),
    .state_d          (state_d),
    .deselect_in_pause(deselect_in_pause)
  );

  spi_hold_outputs i_out (
    .clk              (clk),
    .rst              (rst),
    .state_q          (state_q),
    .state_d          (state_d),
    .deselect_in_pause(deselect_in_pause),
    .cs_n_s           (pins_s.cs_n),
    .sclk_s           (pins_s.sclk),
    .di_s             (pins_s.di),
    .tx_req           (tx_req),
    .hold_active      (hold_active),
    .shift_enable     (shift_enable),
    .do_oe            (do_oe),
    .iface_reset      (iface_reset),
    .bit_strobe       (bit_strobe),
    .bit_data         (bit_data)
  );

  // The busy flag of running program/erase cycles is never touched here.
  assign busy_out = busy_in;
endmodule

// File: rtl/spi_hold_ctl_chk.sv
module spi_hold_ctl_chk (
  input logic clk,
  input logic rst,
  input logic hold_active,
  input logic shift_enable,
  input logic do_oe,
  input logic iface_reset,
  input logic bit_strobe
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!hold_active && !shift_enable && !do_oe && !iface_reset && !bit_strobe)); // R1
  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (rst) hold_active |-> (!shift_enable && !do_oe && !bit_strobe)); // R6
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) iface_reset |=> !iface_reset); // R9
  AST_RESET_AFTER_PAUSE: assert property (@(posedge clk) disable iff (rst) $rose(iface_reset) |-> ($past(hold_active) && !hold_active)); // R9
  AST_STROBE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst) bit_strobe |-> shift_enable); // R11
  AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst) do_oe |-> shift_enable); // R12
endmodule

bind spi_hold_ctl spi_hold_ctl_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .hold_active (hold_active),
  .shift_enable(shift_enable),
  .do_oe       (do_oe),
  .iface_reset (iface_reset),
  .bit_strobe  (bit_strobe)
);

// File: tb/test_spi_hold_ctl.sv
module test_spi_hold_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, hold_n = 1'b1, sclk = 1'b0, di = 1'b0, tx_req = 1'b0, busy_in = 1'b0;
  logic hold_active, shift_enable, do_oe, iface_reset, bit_strobe, bit_data, busy_out;

  int n_chk = 0, n_bad = 0;
  int strobes = 0, resets = 0;
  logic [7:0] rx = '0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_hold_ctl i_spi_hold_ctl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .hold_n(hold_n), .sclk(sclk), .di(di),
    .tx_req(tx_req), .busy_in(busy_in), .hold_active(hold_active),
    .shift_enable(shift_enable), .do_oe(do_oe), .iface_reset(iface_reset),
    .bit_strobe(bit_strobe), .bit_data(bit_data), .busy_out(busy_out)
  );

  always @(negedge clk) begin
    if (!rst && bit_strobe) begin
      strobes <= strobes + 1;
      rx <= {rx[6:0], bit_data};
    end
    if (!rst && iface_reset) resets <= resets + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    di = b; sclk = 1'b0; repeat (4) @(negedge clk);
    sclk = 1'b1; repeat (4) @(negedge clk);
    sclk = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic idle_pins();
    cs_n = 1'b1; hold_n = 1'b1; sclk = 1'b0; di = 1'b0; tx_req = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 hold_active", hold_active, 0);
    chk("R1 shift_enable", shift_enable, 0);
    chk("R1 do_oe", do_oe, 0);
    chk("R1 iface_reset", iface_reset, 0);
    chk("R1 bit_strobe", bit_strobe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle out of reset", {hold_active, shift_enable, do_oe}, 0);
  endtask

  task automatic t_latency();
    cs_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 shift_enable after two edges", shift_enable, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 shift_enable after three edges", shift_enable, 1);
    idle_pins();
  endtask

  task automatic t_not_selected();
    int r0 = resets;
    hold_n = 1'b0; settle();
    chk("R3 no pause while deselected", hold_active, 0);
    chk("R3 no reset pulse", resets - r0, 0);
    hold_n = 1'b1; settle();
  endtask

  task automatic t_entry();
    cs_n = 1'b0; settle();
    hold_n = 1'b0; settle();
    chk("R4 immediate entry, sclk low", hold_active, 1);
    hold_n = 1'b1; settle();
    chk("R5 immediate exit, sclk low", hold_active, 0);
    sclk = 1'b1; settle();
    hold_n = 1'b0; repeat (8) @(negedge clk);
    chk("R4 entry deferred while sclk high", hold_active, 0);
    sclk = 1'b0; settle();
    chk("R4 entry on sclk low", hold_active, 1);
    idle_pins();
  endtask

  task automatic t_exit_deferred();
    cs_n = 1'b0; settle();
    hold_n = 1'b0; settle();
    sclk = 1'b1; settle();
    hold_n = 1'b1; repeat (8) @(negedge clk);
    chk("R5 exit deferred while sclk high", hold_active, 1);
    sclk = 1'b0; settle();
    chk("R5 exit on sclk low", hold_active, 0);
    idle_pins();
  endtask

  task automatic t_freeze_and_keep();
    int s0, r0;
    logic [7:0] pat = 8'hB6;
    cs_n = 1'b0; tx_req = 1'b1; settle();
    s0 = strobes; r0 = resets;
    for (int i = 7; i >= 5; i--) clk_bit(pat[i]);
    hold_n = 1'b0; settle();
    chk("R6 shift_enable low in pause", shift_enable, 0);
    chk("R6 do_oe low in pause", do_oe, 0);
    for (int k = 0; k < 3; k++) clk_bit(k[0]);
    chk("R6 no strobes in pause", strobes - s0, 3);
    hold_n = 1'b1; settle();
    for (int i = 4; i >= 0; i--) clk_bit(pat[i]);
    chk("R7 total bits across pause", strobes - s0, 8);
    chk("R7 assembled byte", rx, pat);
    chk("R7 no reset pulse", resets - r0, 0);
    idle_pins();
  endtask

  task automatic t_strobe_data();
    int s0 = strobes;
    clk_bit(1'b1); clk_bit(1'b1);
    chk("R11 no strobe while deselected", strobes - s0, 0);
    cs_n = 1'b0; settle();
    for (int i = 7; i >= 0; i--) clk_bit(i[0] ^ i[1]);
    chk("R11 one strobe per edge", strobes - s0, 8);
    chk("R11 data bits", rx, 8'b0110_0110);
    idle_pins();
  endtask

  task automatic t_oe();
    cs_n = 1'b0; settle();
    chk("R12 oe low without request", do_oe, 0);
    tx_req = 1'b1; @(posedge clk); @(negedge clk);
    chk("R12 oe one cycle after request", do_oe, 1);
    tx_req = 1'b0; @(posedge clk); @(negedge clk);
    chk("R12 oe drops with request", do_oe, 0);
    idle_pins();
  endtask

  task automatic t_lockout();
    int r0;
    busy_in = 1'b1;
    cs_n = 1'b0; settle();
    hold_n = 1'b0; settle();
    chk("R8 busy during pause", busy_out, 1);
    r0 = resets;
    cs_n = 1'b1; settle();
    chk("R9 one reset pulse", resets - r0, 1);
    chk("R9 pause cleared", hold_active, 0);
    chk("R8 busy after deselect", busy_out, 1);
    cs_n = 1'b0; settle();
    chk("R10 no re-entry when reselected", hold_active, 0);
    chk("R10 shift locked", shift_enable, 0);
    hold_n = 1'b1; settle();
    chk("R10 still locked, hold released while selected", shift_enable, 0);
    cs_n = 1'b1; settle();
    cs_n = 1'b0; settle();
    chk("R10 normal after release", shift_enable, 1);
    busy_in = 1'b0; #1;
    chk("R8 busy follows input", busy_out, 0);
    chk("R9 no further pulse", resets - r0, 1);
    idle_pins();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    settle();
    t_latency();
    t_not_selected();
    t_entry();
    t_exit_deferred();
    t_freeze_and_keep();
    t_strobe_data();
    t_oe();
    t_lockout();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule